// File: doc/BRIEF.md
# Compare-Immediate Condition Field Unit

This unit carries out compare-with-immediate operations for a register-based processor core. An execute request delivers a register operand, a 16-bit immediate taken from the instruction, a signed/unsigned select, a width select and a 3-bit condition field number. The unit works out whether the operand is less than, greater than or equal to the extended immediate. It then writes that result into one 4-bit field of a 32-bit condition register that the unit owns.

The condition register is visible at all times on a read port, so branch logic and other consumers can sample it. Each request is accepted in a single cycle. The selected field is updated on the clock edge that accepts the request, and every other bit of the register keeps its value. Register file access and instruction decode sit outside the unit; the operand value arrives already read.

Top module: `cmpi_cr_unit`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, the condition register reads zero.
- R2: When `req_signed` is 1, the immediate is sign-extended and both sides are compared as two's-complement numbers. For example, an immediate of 0x8000 means -32768 and 0xFFFF means -1.
- R3: When `req_signed` is 0, the immediate is zero-extended and both sides are compared as unsigned numbers. For example, 0x8000 means 32768 and 0xFFFF means 65535.
- R4: `req_field` value n selects condition register bits [31-4n : 28-4n]. Field 0 is bits 31:28 and field 7 is bits 3:0.
- R5: In the written field, bit 3 is less-than, bit 2 is greater-than and bit 1 is equal. Exactly one of these three bits is set.
- R6: An accepted request changes no condition register bit outside the selected field.
- R7: Bit 0 of the written field is always written as 0.
- R8: When `req_wide` is 1, the full 64-bit operand is compared. When it is 0, only operand bits 31:0 are compared, taken as signed or unsigned to match `req_signed`, and bits 63:32 have no effect on the result.
- R9: An accepted request (`req_valid` and `req_ready` both high at a rising edge) shows its result on `cr_value` right after that edge. With `req_valid` low, `cr_value` holds its value whatever the other inputs carry.
- R10: `req_ready` is low during reset and high from the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Execute request present |
| req_ready | output | 1 | Unit can accept a request this cycle |
| req_operand | input | 64 | Register operand value |
| req_imm | input | 16 | Immediate field of the instruction |
| req_signed | input | 1 | 1 selects a signed compare, 0 an unsigned compare |
| req_wide | input | 1 | 1 selects a 64-bit compare, 0 a 32-bit compare |
| req_field | input | 3 | Target condition field number, 0 to 7 |
| cr_value | output | 32 | Condition register read port |

## Verification
The bench builds the unit with its defaults: a 64-bit operand, a 16-bit immediate and eight 4-bit fields. With these values the narrow compare covers exactly the low half of the operand. Setting upper operand bits that contradict the low half therefore shows that the narrow mode ignores them. The reference model checks the immediate boundary values 0x7FFF, 0x8000 and 0xFFFF in both signed and unsigned modes, against operands on either side of each value. It also writes every one of the eight fields over a known background pattern, so a slice that lands on the wrong bits, or that overwrites its neighbours, shows up at once.

// File: rtl/cmpi_pkg.sv
package cmpi_pkg;
  localparam int NIB_W = 4;

  // Compare flags, from most to least significant bit of a field
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
  } cmp_flags_t;
endpackage

// File: rtl/cmpi_compare.sv
module cmpi_compare
  import cmpi_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 16
) (
  input  logic [XLEN-1:0]  operand,
  input  logic [IMM_W-1:0] imm,
  input  logic             is_signed,
  input  logic             is_wide,
  output cmp_flags_t       flags
);
  localparam int HALF = XLEN / 2;

  // Both sides are widened by one bit so that a single signed compare
  // serves the signed and the unsigned forms alike.
  logic [XLEN:0] a_ext;
  logic [XLEN:0] b_ext;

  always_comb begin
    if (is_wide)
      a_ext = {is_signed & operand[XLEN-1], operand};
    else
      a_ext = {{(XLEN-HALF+1){is_signed & operand[HALF-1]}}, operand[HALF-1:0]};
    b_ext = {{(XLEN+1-IMM_W){is_signed & imm[IMM_W-1]}}, imm};
  end

  always_comb begin
    flags.lt = $signed(a_ext) <  $signed(b_ext);
    flags.gt = $signed(a_ext) >  $signed(b_ext);
    flags.eq = a_ext == b_ext;
  end
endmodule

// File: rtl/cmpi_cr_merge.sv
module cmpi_cr_merge
  import cmpi_pkg::*;
#(
  parameter int NFIELD = 8,
  localparam int FSEL_W = $clog2(NFIELD),
  localparam int CR_W   = NFIELD * NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [FSEL_W-1:0] wr_field,
  input  cmp_flags_t        wr_flags,
  output logic [CR_W-1:0]   cr_q
);
  logic [NIB_W-1:0] fld_q [NFIELD];

  // Field 0 sits at the top of the register; higher numbers move down.
  for (genvar f = 0; f < NFIELD; f++) begin : g_field
    always_ff @(posedge clk) begin
      if (rst)
        fld_q[f] <= '0;
      else if (wr_en && wr_field == FSEL_W'(f))
        fld_q[f] <= {wr_flags, 1'b0};
    end
    assign cr_q[CR_W-1-NIB_W*f -: NIB_W] = fld_q[f];
  end

  // Masks derived by shifting, independent of the per-field write logic
  logic [CR_W-1:0] sel_mask;
  logic [CR_W-1:0] lsb_mask;
  always_comb begin
    sel_mask = {{NIB_W{1'b1}}, {(CR_W-NIB_W){1'b0}}} >> (NIB_W * int'(wr_field));
    lsb_mask = {{(NIB_W-1){1'b0}}, 1'b1, {(CR_W-NIB_W){1'b0}}} >> (NIB_W * int'(wr_field));
  end

  p_other_hold_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((cr_q ^ $past(cr_q)) & ~$past(sel_mask)) == '0);

  p_lsb_zero_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (cr_q & $past(lsb_mask)) == '0);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cr_q));
endmodule

// File: rtl/cmpi_cr_unit.sv
module cmpi_cr_unit
  import cmpi_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int IMM_W  = 16,
  parameter int NFIELD = 8,
  localparam int FSEL_W = $clog2(NFIELD),
  localparam int CR_W   = NFIELD * NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [XLEN-1:0]   req_operand,
  input  logic [IMM_W-1:0]  req_imm,
  input  logic              req_signed,
  input  logic              req_wide,
  input  logic [FSEL_W-1:0] req_field,
  output logic [CR_W-1:0]   cr_value
);
  logic       ready_q;
  logic       fire;
  cmp_flags_t flags;

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else     ready_q <= 1'b1;
  end

  assign req_ready = ready_q;
  assign fire      = req_valid & ready_q;

  cmpi_compare #(.XLEN(XLEN), .IMM_W(IMM_W)) i_compare (
    .operand   (req_operand),
    .imm       (req_imm),
    .is_signed (req_signed),
    .is_wide   (req_wide),
    .flags     (flags)
  );

  cmpi_cr_merge #(.NFIELD(NFIELD)) i_merge (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (fire),
    .wr_field (req_field),
    .wr_flags (flags),
    .cr_q     (cr_value)
  );

  p_one_flag_r5: assert property (@(posedge clk) disable iff (rst)
    fire |-> $countones({flags.lt, flags.gt, flags.eq}) == 1);

  p_ready_after_reset_r10: assert property (@(posedge clk) disable iff (rst)
    !rst |=> req_ready);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> cr_value == '0);
endmodule

// File: tb/test_cmpi_cr_unit.sv
`timescale 1ns/1ps
module test_cmpi_cr_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_operand = '0;
  logic [15:0] req_imm = '0;
  logic        req_signed = 1'b0;
  logic        req_wide = 1'b0;
  logic [2:0]  req_field = '0;
  logic [31:0] cr_value;

  int n_checks = 0;
  int n_errors = 0;
  logic [31:0] model_cr = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmpi_cr_unit i_cmpi_cr_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_operand(req_operand), .req_imm(req_imm), .req_signed(req_signed),
    .req_wide(req_wide), .req_field(req_field), .cr_value(cr_value)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Behavioural reference: lt/gt/eq in bits 3..1, bit 0 zero
  function automatic logic [3:0] ref_nib(input logic [63:0] op, input logic [15:0] imm,
                                         input bit sgn, input bit wide);
    bit lt, gt, eq;
    if (wide && sgn) begin
      longint a = longint'(op);
      longint b = longint'(signed'(imm));
      lt = a < b; gt = a > b; eq = a == b;
    end else if (wide) begin
      longint unsigned a = op;
      longint unsigned b = {48'h0, imm};
      lt = a < b; gt = a > b; eq = a == b;
    end else if (sgn) begin
      int a = int'(op[31:0]);
      int b = int'(signed'(imm));
      lt = a < b; gt = a > b; eq = a == b;
    end else begin
      int unsigned a = op[31:0];
      int unsigned b = {16'h0, imm};
      lt = a < b; gt = a > b; eq = a == b;
    end
    return {lt, gt, eq, 1'b0};
  endfunction

  // One cycle: drive at falling edge, model the rising edge, compare at next falling edge
  task automatic step(input string req, input bit v, input logic [63:0] op,
                      input logic [15:0] imm, input bit sgn, input bit wide,
                      input logic [2:0] fld);
    @(negedge clk);
    req_valid = v; req_operand = op; req_imm = imm;
    req_signed = sgn; req_wide = wide; req_field = fld;
    if (v) model_cr[31-4*fld -: 4] = ref_nib(op, imm, sgn, wide);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req, cr_value, model_cr);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset clears register", cr_value, 32'h0);
    chk("R10 ready low in reset", {31'h0, req_ready}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 register zero after reset", cr_value, 32'h0);
    chk("R10 ready high after reset", {31'h0, req_ready}, 32'h1);

    // R2 / R3: immediate boundaries, both modes, operand around each value
    foreach (model_cr[i]) begin end
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < 3; k++) begin
        logic [15:0] im = (k == 0) ? 16'h7FFF : (k == 1) ? 16'h8000 : 16'hFFFF;
        logic [63:0] base = s ? 64'(longint'(signed'(im))) : {48'h0, im};
        for (int d = -1; d <= 1; d++) begin
          step(s ? "R2 signed immediate boundary" : "R3 unsigned immediate boundary",
               1'b1, base + 64'(longint'(d)), im, s[0], 1'b1, 3'(k));
          step(s ? "R2 signed narrow boundary" : "R3 unsigned narrow boundary",
               1'b1, base + 64'(longint'(d)), im, s[0], 1'b0, 3'(k + 3));
        end
      end
    end

    // R4 / R6: every field over a known background
    for (int f = 0; f < 8; f++)
      step("R4 field placement and R6 neighbours kept", 1'b1, 64'd5, 16'd9, 1'b0, 1'b1, 3'(f));
    for (int f = 0; f < 8; f++)
      step("R5 equal flag position", 1'b1, 64'd9, 16'd9, 1'b1, 1'b0, 3'(f));
    step("R5 greater flag position", 1'b1, 64'd100, 16'd9, 1'b0, 1'b1, 3'd2);
    chk("R4 field 2 reads greater-than", {28'h0, cr_value[23:20]}, 32'h4);
    step("R7 lsb zero with less-than", 1'b1, 64'd1, 16'd9, 1'b0, 1'b1, 3'd7);
    chk("R7 field 7 lsb zero", {28'h0, cr_value[3:0]}, 32'h8);

    // R8: upper operand bits contradict the low half
    step("R8 narrow ignores upper bits", 1'b1, 64'hFFFF_FFFF_0000_0003, 16'd3, 1'b0, 1'b0, 3'd1);
    chk("R8 narrow equal", {28'h0, cr_value[27:24]}, 32'h2);
    step("R8 wide sees upper bits", 1'b1, 64'hFFFF_FFFF_0000_0003, 16'd3, 1'b0, 1'b1, 3'd1);
    chk("R8 wide unsigned greater", {28'h0, cr_value[27:24]}, 32'h4);
    step("R8 narrow signed negative", 1'b1, 64'h0000_0000_8000_0000, 16'd0, 1'b1, 1'b0, 3'd6);
    chk("R8 narrow signed less", {28'h0, cr_value[7:4]}, 32'h8);

    // R9: idle cycles with busy inputs leave the register alone
    for (int i = 0; i < 6; i++)
      step("R9 idle holds register", 1'b0, {$urandom, $urandom}, 16'($urandom), 1'b1, 1'b0, 3'(i));

    // Mixed traffic against the model
    for (int i = 0; i < 300; i++) begin
      logic [63:0] op = {$urandom, $urandom};
      logic [15:0] im = 16'($urandom);
      if (i % 3 == 0) op = {$urandom, 16'(im + 16'($urandom % 3) - 16'd1), 16'h0} >> 16;
      step("R9 mixed traffic", ($urandom % 4) != 0, op, im, 1'($urandom), 1'($urandom),
           3'($urandom));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule